// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block holds ten 32-bit performance counters for a memory controller. Each counter picks one line of a 32-line event bus. It counts on a cycle only when that line is active and a 45-bit qualifier word passes a mask/match comparison. An invert control can negate the comparison. On each qualifying cycle the counter adds a programmable step of 1 to 4. Counters 0 to 7 belong to a half-rate group, which advances only on cycles where a clock-enable strobe is high. Counters 8 and 9 advance on every cycle.

Software programs the bank through a simple 32-bit register bus with write and read strobes. Read data is registered. When a counter wraps, it sets a sticky overflow bit in its group's status register. A single interrupt line stays high while any of those bits is set. Software can preload a start value, freeze and resume a counter, and capture a snapshot of the live count.

Top module: `evt_counter_bank`

## Requirements
- R1: After synchronous reset, every readable register reads zero and `irq` is low.
- R2: Counter i owns a 40-byte window starting at byte 16+40*i. Mask and match are 45 bits each. Bits 31:0 of the mask sit at window offset +0 and bits 44:32 at +4. The match uses +8 and +12 in the same way. Bits above 12 of a high word read zero. An event qualifies when `evt_in[sel]` is 1 and (qualifier AND mask) equals (match AND mask).
- R3: The control register sits at window offset +16. Bit 0 is enable, bit 1 is invert, bits 6:2 are the event select, and bits 8:7 are the step code. Bits 31:9 read zero.
- R4: With invert set, the mask/match result is negated before it gates the count. The selected event line must still be 1.
- R5: A qualifying cycle adds step code + 1. On a wrap the counter keeps the low 32 bits. A bus write to the live value at +32 loads it, and the write takes priority over counting in the same cycle.
- R6: Counters 0–7 advance only in cycles where `half_en` is 1. Counters 8–9 advance in any qualifying cycle.
- R7: A wrap sets that counter's sticky bit. The half-rate group's status is at byte 8, bits 7:0. The full-rate group's status is at byte 12, bits 1:0. `irq` is high in every cycle after an edge that leaves any status bit set.
- R8: Writing zero to a status register clears that group's bits. Writing a nonzero value has no effect. A wrap in the same cycle as a clear leaves its bit set.
- R9: With enable clear, the counter holds its value. Setting enable again resumes counting from the held value.
- R10: Any write to window offset +24 copies the live value into the snapshot register at the clock edge of the write, taking the value from before that edge's increment. The snapshot reads back at +24.
- R11: `rdata` changes only on a cycle with `rd_en` and shows the addressed register one cycle later. Unmapped or unaligned addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| half_en | input | 1 | Clock-enable strobe for the half-rate group |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_in | input | 32 | Event lines, one per select code |
| qual_in | input | 45 | Qualifier word compared under the mask |
| irq | output | 1 | Level interrupt, high while any overflow bit is set |

## Verification
The bench aims at the following corner cases:
- **Preload just below full scale.** This forces wraps in both groups. A design that lost the carry would never raise `irq`, and one that saturated would read back the wrong value.
- **Status clear in the same cycle as a wrap.** A design that let the clear win would drop an overflow.
- **Nonzero write to a status register.** A design that treated this as a clear would lower the interrupt too early.
- **Qualifier differing only in bit 44, and invert set.** These expose a truncated high word or an invert that also masks the event line.
- **Snapshot write while the counter runs.** This shows whether the captured value is taken before or after the same-cycle increment.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;
  localparam int BUS_W = 32;
  localparam int SEL_W = 5;
  localparam int INC_W = 2;

  typedef struct packed {
    logic [INC_W-1:0] inc;
    logic [SEL_W-1:0] sel;
    logic             inv;
    logic             en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // register map: behaviour-relevant offsets
  localparam int ST_SLOW_ADR  = 8;
  localparam int ST_FAST_ADR  = 12;
  localparam int WIN_START    = 16;
  localparam int WIN_BYTES    = 40;
  localparam int OFF_MASK_LO  = 0;
  localparam int OFF_MASK_HI  = 4;
  localparam int OFF_MATCH_LO = 8;
  localparam int OFF_MATCH_HI = 12;
  localparam int OFF_CTL      = 16;
  localparam int OFF_SNAP     = 24;
  localparam int OFF_VAL      = 32;
endpackage

// File: rtl/evt_filter.sv
module evt_filter
  import evt_bank_pkg::*;
#(
  parameter int FILT_W = 45,
  parameter int EVT_W  = 32
) (
  input  logic [EVT_W-1:0]  evt,
  input  logic [FILT_W-1:0] qual,
  input  logic [FILT_W-1:0] mask,
  input  logic [FILT_W-1:0] match,
  input  ctl_t              ctl,
  output logic              pass,
  output logic [INC_W:0]    step
);
  logic same;

  always_comb begin
    same = (((qual ^ match) & mask) == '0);
    pass = evt[ctl.sel] & (same ^ ctl.inv);
    step = {1'b0, ctl.inc} + (INC_W+1)'(1);
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evt_bank_pkg::*;
#(
  parameter int CTR_W   = 32,
  parameter int FILT_W  = 45,
  parameter int EVT_W   = 32,
  parameter int ADDR_W  = 10,
  parameter int BASE    = 16,
  parameter bit IS_SLOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic [FILT_W-1:0] qual_in,
  output logic [BUS_W-1:0]  rd_word,
  output logic              ovf
);
  localparam int HI_W = FILT_W - 32;
  localparam logic [ADDR_W:0] BASE_A = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] LIM_A  = (ADDR_W+1)'(BASE + WIN_BYTES);
  localparam logic [5:0]      BASE_L = 6'(BASE);

  logic [FILT_W-1:0] mask_q, match_q;
  ctl_t              ctl_q;
  logic [CTR_W-1:0]  val_q, snap_q;
  logic              hit;
  logic [5:0]        loc;
  logic              wr_mlo, wr_mhi, wr_tlo, wr_thi, wr_ctl, wr_snap, wr_val;
  logic              pass, tick;
  logic [INC_W:0]    step;
  logic [CTR_W:0]    sum;

  evt_filter #(.FILT_W(FILT_W), .EVT_W(EVT_W)) u_filt (
    .evt(evt_in), .qual(qual_in), .mask(mask_q), .match(match_q),
    .ctl(ctl_q), .pass(pass), .step(step)
  );

  always_comb begin
    hit     = ({1'b0, addr} >= BASE_A) && ({1'b0, addr} < LIM_A);
    loc     = addr[5:0] - BASE_L;
    wr_mlo  = wr_en && hit && (loc == 6'(OFF_MASK_LO));
    wr_mhi  = wr_en && hit && (loc == 6'(OFF_MASK_HI));
    wr_tlo  = wr_en && hit && (loc == 6'(OFF_MATCH_LO));
    wr_thi  = wr_en && hit && (loc == 6'(OFF_MATCH_HI));
    wr_ctl  = wr_en && hit && (loc == 6'(OFF_CTL));
    wr_snap = wr_en && hit && (loc == 6'(OFF_SNAP));
    wr_val  = wr_en && hit && (loc == 6'(OFF_VAL));
    tick    = ctl_q.en && pass && (!IS_SLOW || half_en);
    sum     = {1'b0, val_q} + (CTR_W+1)'(step);
    ovf     = tick && !wr_val && sum[CTR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      match_q <= '0;
      ctl_q   <= '0;
      val_q   <= '0;
      snap_q  <= '0;
    end else begin
      if (wr_mlo) mask_q[31:0]         <= wdata;
      if (wr_mhi) mask_q[FILT_W-1:32]  <= wdata[HI_W-1:0];
      if (wr_tlo) match_q[31:0]        <= wdata;
      if (wr_thi) match_q[FILT_W-1:32] <= wdata[HI_W-1:0];
      if (wr_ctl) ctl_q                <= ctl_t'(wdata[CTL_W-1:0]);
      if (wr_snap) snap_q              <= val_q;
      if (wr_val)    val_q <= wdata[CTR_W-1:0];
      else if (tick) val_q <= sum[CTR_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit) begin
      case (loc)
        6'(OFF_MASK_LO):  rd_word = mask_q[31:0];
        6'(OFF_MASK_HI):  rd_word = BUS_W'(mask_q[FILT_W-1:32]);
        6'(OFF_MATCH_LO): rd_word = match_q[31:0];
        6'(OFF_MATCH_HI): rd_word = BUS_W'(match_q[FILT_W-1:32]);
        6'(OFF_CTL):      rd_word = BUS_W'(ctl_q);
        6'(OFF_SNAP):     rd_word = BUS_W'(snap_q);
        6'(OFF_VAL):      rd_word = BUS_W'(val_q);
        default:          rd_word = '0;
      endcase
    end
  end

  // R5
  preload_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_val |=> val_q == $past(wdata[CTR_W-1:0]));

  // R9
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.en && !wr_val) |=> val_q == $past(val_q));

  // R6
  half_rate_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (IS_SLOW && !half_en && !wr_val) |=> val_q == $past(val_q));

  // R10
  snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
    wr_snap |=> snap_q == $past(val_q));
endmodule

// File: rtl/ovf_status.sv
module ovf_status #(
  parameter int N_SLOW = 8,
  parameter int N_FAST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_slow,
  input  logic              clr_fast,
  input  logic [N_SLOW-1:0] set_slow,
  input  logic [N_FAST-1:0] set_fast,
  output logic [N_SLOW-1:0] st_slow,
  output logic [N_FAST-1:0] st_fast,
  output logic              irq
);
  logic [N_SLOW-1:0] nxt_slow;
  logic [N_FAST-1:0] nxt_fast;

  always_comb begin
    nxt_slow = (clr_slow ? '0 : st_slow) | set_slow;
    nxt_fast = (clr_fast ? '0 : st_fast) | set_fast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_slow <= '0;
      st_fast <= '0;
      irq     <= 1'b0;
    end else begin
      st_slow <= nxt_slow;
      st_fast <= nxt_fast;
      irq     <= (|nxt_slow) || (|nxt_fast);
    end
  end

  // R7
  sticky_slow_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_slow |=> (st_slow & $past(st_slow)) == $past(st_slow));

  // R7
  sticky_fast_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_fast |=> (st_fast & $past(st_fast)) == $past(st_fast));

  // R8
  clear_slow_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_slow && set_slow == '0) |=> st_slow == '0);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((|st_slow) && !clr_slow) |=> irq);
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import evt_bank_pkg::*;
#(
  parameter int NUM_CTR  = 10,
  parameter int NUM_SLOW = 8,
  parameter int CTR_W    = 32,
  parameter int FILT_W   = 45,
  parameter int ADDR_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [(1<<SEL_W)-1:0] evt_in,
  input  logic [FILT_W-1:0] qual_in,
  output logic              irq
);
  localparam int EVT_W    = 1 << SEL_W;
  localparam int NUM_FAST = NUM_CTR - NUM_SLOW;

  logic [BUS_W-1:0]    rd_words [NUM_CTR];
  logic [NUM_CTR-1:0]  ovf;
  logic [NUM_SLOW-1:0] st_slow;
  logic [NUM_FAST-1:0] st_fast;
  logic                clr_slow, clr_fast;
  logic [BUS_W-1:0]    rd_mux;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    evt_counter #(
      .CTR_W(CTR_W), .FILT_W(FILT_W), .EVT_W(EVT_W), .ADDR_W(ADDR_W),
      .BASE(WIN_START + WIN_BYTES * i), .IS_SLOW(i < NUM_SLOW)
    ) u_ctr (
      .clk(clk), .rst(rst), .half_en(half_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .evt_in(evt_in), .qual_in(qual_in),
      .rd_word(rd_words[i]), .ovf(ovf[i])
    );
  end

  always_comb begin
    clr_slow = wr_en && (addr == ADDR_W'(ST_SLOW_ADR)) && (wdata == '0);
    clr_fast = wr_en && (addr == ADDR_W'(ST_FAST_ADR)) && (wdata == '0);
  end

  ovf_status #(.N_SLOW(NUM_SLOW), .N_FAST(NUM_FAST)) u_sts (
    .clk(clk), .rst(rst), .clr_slow(clr_slow), .clr_fast(clr_fast),
    .set_slow(ovf[NUM_SLOW-1:0]), .set_fast(ovf[NUM_CTR-1:NUM_SLOW]),
    .st_slow(st_slow), .st_fast(st_fast), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CTR; i++) rd_mux = rd_mux | rd_words[i];
    if (addr == ADDR_W'(ST_SLOW_ADR)) rd_mux = BUS_W'(st_slow);
    if (addr == ADDR_W'(ST_FAST_ADR)) rd_mux = BUS_W'(st_fast);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_evt_counter_bank.sv
`timescale 1ns/1ps
module test_evt_counter_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        half_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] evt_in = '0;
  logic [44:0] qual_in = '0;
  logic        irq;

  evt_counter_bank i_evt_counter_bank (
    .clk(clk), .rst(rst), .half_en(half_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .evt_in(evt_in),
    .qual_in(qual_in), .irq(irq)
  );

  always #2 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  bit    live = 1'b0;
  string cur_tag = "";

  // behavioural reference state
  logic [44:0] m_mask [10];
  logic [44:0] m_match [10];
  logic [8:0]  m_ctl [10];
  logic [31:0] m_val [10];
  logic [31:0] m_snap [10];
  logic [7:0]  m_sts;
  logic [1:0]  m_stf;
  logic [31:0] exp_rdata;
  logic        exp_irq;
  bit          was_rd;
  string       last_tag;

  function automatic logic [31:0] model_read(input logic [9:0] a);
    int s, k;
    if (a == 10'd8)  return {24'd0, m_sts};
    if (a == 10'd12) return {30'd0, m_stf};
    if (a >= 10'd16 && a < 10'd416) begin
      k = (int'(a) - 16) / 40;
      s = (int'(a) - 16) % 40;
      case (s)
        0:  return m_mask[k][31:0];
        4:  return {19'd0, m_mask[k][44:32]};
        8:  return m_match[k][31:0];
        12: return {19'd0, m_match[k][44:32]};
        16: return {23'd0, m_ctl[k]};
        24: return m_snap[k];
        32: return m_val[k];
        default: return 32'd0;
      endcase
    end
    return 32'd0;
  endfunction

  function automatic string tag_for(input logic [9:0] a);
    int s;
    if (cur_tag != "") return cur_tag;
    if (a == 10'd8 || a == 10'd12) return "R7";
    if (a >= 10'd16 && a < 10'd416) begin
      s = (int'(a) - 16) % 40;
      if (s == 0 || s == 4 || s == 8 || s == 12) return "R2";
      if (s == 16) return "R3";
      if (s == 24) return "R10";
      if (s == 32) return "R5";
    end
    return "R11";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 10; i++) begin
        m_mask[i] = '0; m_match[i] = '0; m_ctl[i] = '0;
        m_val[i] = '0;  m_snap[i] = '0;
      end
      m_sts = '0; m_stf = '0; exp_rdata = '0; exp_irq = 1'b0; was_rd = 1'b0;
    end else begin
      logic [7:0] ns;
      logic [1:0] nf;
      ns = '0; nf = '0;
      was_rd = rd_en;
      if (rd_en) begin
        exp_rdata = model_read(addr);
        last_tag = tag_for(addr);
      end
      for (int i = 0; i < 10; i++) begin
        int  b;
        bit  ok, go;
        logic [32:0] sum;
        b  = 16 + 40 * i;
        ok = ((qual_in & m_mask[i]) == (m_match[i] & m_mask[i]));
        if (m_ctl[i][1]) ok = !ok;
        go = m_ctl[i][0] && evt_in[m_ctl[i][6:2]] && ok && (i >= 8 || half_en);
        if (wr_en && int'(addr) == b + 24) m_snap[i] = m_val[i];
        if (wr_en && int'(addr) == b + 32) m_val[i] = wdata;
        else if (go) begin
          sum = {1'b0, m_val[i]} + 33'(m_ctl[i][8:7]) + 33'd1;
          m_val[i] = sum[31:0];
          if (sum[32]) begin
            if (i < 8) ns[i] = 1'b1; else nf[i-8] = 1'b1;
          end
        end
        if (wr_en && int'(addr) == b)      m_mask[i][31:0]   = wdata;
        if (wr_en && int'(addr) == b + 4)  m_mask[i][44:32]  = wdata[12:0];
        if (wr_en && int'(addr) == b + 8)  m_match[i][31:0]  = wdata;
        if (wr_en && int'(addr) == b + 12) m_match[i][44:32] = wdata[12:0];
        if (wr_en && int'(addr) == b + 16) m_ctl[i] = wdata[8:0];
      end
      if (wr_en && addr == 10'd8 && wdata == 0)  m_sts = '0;
      if (wr_en && addr == 10'd12 && wdata == 0) m_stf = '0;
      m_sts = m_sts | ns;
      m_stf = m_stf | nf;
      exp_irq = (m_sts != 0) || (m_stf != 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R7 irq", {31'd0, irq}, {31'd0, exp_irq});
      if (was_rd) chk(last_tag, rdata, exp_rdata);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    half_en = ~half_en;
    rd_en = 1'b0; wr_en = 1'b1; addr = 10'(a); wdata = d;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    half_en = ~half_en;
    wr_en = 1'b0; rd_en = 1'b1; addr = 10'(a);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      half_en = ~half_en;
      wr_en = 1'b0; rd_en = 1'b0;
    end
  endtask

  function automatic int wb(input int i, input int off);
    return 16 + 40 * i + off;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;

    // R1: reset contents
    cur_tag = "R1";
    rd(8); rd(12); rd(0);
    for (int o = 0; o <= 32; o += 4) begin
      rd(wb(0, o));
      rd(wb(9, o));
    end
    idle(1);

    // R6: half-rate counter 0 and R5 full-rate counter 8 with step 4
    cur_tag = "R6";
    evt_in = 32'h0000_0028;
    wr(wb(0, 16), 32'h0D);
    idle(9);
    rd(wb(0, 32));
    cur_tag = "R5";
    wr(wb(8, 16), 32'h195);
    idle(6);
    rd(wb(8, 32));
    rd(wb(8, 16));

    // R2: filter on bit 44 and low bits
    cur_tag = "R2";
    wr(wb(1, 0), 32'h0F); wr(wb(1, 4), 32'h1000);
    wr(wb(1, 8), 32'h05); wr(wb(1, 12), 32'hFFFF_1000);
    rd(wb(1, 12));
    qual_in = {13'h1000, 32'h0000_0005};
    wr(wb(1, 16), 32'h0D);
    idle(6);
    rd(wb(1, 32));
    qual_in = {13'h0000, 32'h0000_0005};
    idle(6);
    rd(wb(1, 32));

    // R4: invert, event line still required
    cur_tag = "R4";
    wr(wb(2, 0), 32'h0F); wr(wb(2, 4), 32'h1000);
    wr(wb(2, 8), 32'h05); wr(wb(2, 12), 32'h1000);
    wr(wb(2, 16), 32'h0F);
    idle(6);
    rd(wb(2, 32));
    evt_in = 32'h0;
    idle(4);
    rd(wb(2, 32));
    evt_in = 32'h0000_0028;

    // R9: freeze then resume
    cur_tag = "R9";
    wr(wb(0, 16), 32'h0C);
    idle(5);
    rd(wb(0, 32));
    idle(3);
    rd(wb(0, 32));
    wr(wb(0, 16), 32'h0D);
    idle(4);
    rd(wb(0, 32));

    // R7: full-rate and half-rate overflow
    cur_tag = "R7";
    wr(wb(9, 16), 32'h0D);
    wr(wb(9, 32), 32'hFFFF_FFFE);
    idle(4);
    rd(12); rd(wb(9, 32));
    wr(wb(3, 16), 32'h0D);
    wr(wb(3, 32), 32'hFFFF_FFFF);
    idle(4);
    rd(8);

    // R8: nonzero write ignored, zero clears, coincident wrap survives
    cur_tag = "R8";
    wr(12, 32'h3);
    rd(12);
    wr(8, 32'h0);
    wr(12, 32'h0);
    rd(12); rd(8);
    wr(wb(9, 32), 32'hFFFF_FFFF);
    wr(12, 32'h0);
    rd(12);
    wr(12, 32'h0);
    wr(wb(9, 16), 32'h0);
    wr(12, 32'h0);
    rd(12);

    // R10: snapshot while running
    cur_tag = "R10";
    wr(wb(8, 24), 32'hDEAD_BEEF);
    rd(wb(8, 24));
    idle(3);
    rd(wb(8, 24));
    rd(wb(8, 32));

    // R11: unmapped and unaligned
    cur_tag = "R11";
    wr(0, 32'hFFFF_FFFF); wr(17, 32'hFFFF_FFFF); wr(wb(4, 36), 32'h1234);
    rd(0); rd(4); rd(17); rd(wb(4, 36)); rd(420); rd(wb(4, 16));
    idle(2);
    rd(wb(4, 0));

    // mixed traffic
    cur_tag = "";
    for (int c = 0; c < 6000; c++) begin
      int r, k, s;
      int offs [8] = '{0, 4, 8, 12, 16, 24, 32, 36};
      @(negedge clk);
      half_en = 1'($urandom);
      evt_in  = $urandom;
      qual_in = {13'($urandom % 4), 32'($urandom % 8)};
      r = $urandom % 8;
      k = $urandom % 10;
      s = offs[$urandom % 8];
      wr_en = 1'b0; rd_en = 1'b0;
      if (r < 2) begin
        wr_en = 1'b1;
        if ($urandom % 8 == 0) begin
          addr  = ($urandom % 2) ? 10'd8 : 10'd12;
          wdata = ($urandom % 2) ? 32'd0 : $urandom;
        end else begin
          addr = 10'(wb(k, s));
          case (s)
            16:      wdata = $urandom % 512;
            32:      wdata = $urandom | 32'hFFFF_FF00;
            0, 4:    wdata = $urandom & 32'h7;
            default: wdata = $urandom & 32'h7;
          endcase
        end
      end else if (r < 5) begin
        rd_en = 1'b1;
        addr  = ($urandom % 6 == 0) ? 10'(8 + 4 * ($urandom % 2)) : 10'(wb(k, s));
      end
    end
    idle(3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule